// File: doc/BRIEF.md
# Baud Tick Source Selector

This block produces the sampling-rate enable for one serial transmitter or receiver. It runs entirely on a single reference clock. From that clock it derives a tick enable at sixteen times the chosen baud rate. A 5-bit select code chooses what drives the tick:

- one of twenty-two internal divided rates;
- one of two general-purpose clock inputs;
- one of two counter/timer outputs;
- an external pin clock, used either as a 16x clock or as a 1x clock.

Every external input passes through a two-flop synchronizer. Each rising edge of the selected input then becomes a tick that lasts exactly one cycle. When the code selects the external pin as a 1x clock, a separate flag tells the attached transmitter or receiver that each tick is one whole bit time. Reserved codes select no source.

A small controller decides what drives the tick. It has five states:

- `ST_HALT`: a reserved code is held; there are no ticks.
- `ST_SETTLE`: a one-cycle gap after any code change, during which the divider is cleared.
- `ST_DIVIDE`: an internal rate is held.
- `ST_FOLLOW`: a general-purpose, timer or pin 16x code is held.
- `ST_FOLLOW_1X`: the pin 1x code is held.

Every clock edge that sees the select code differ from the stored code moves the controller to `ST_SETTLE`. Every edge that sees the code unchanged moves it to the state that the stored code decodes to. Reset enters `ST_HALT` with the stored code set to 11111.

Top module: `baud_src_sel`

## Requirements
- R1: While reset is asserted and after it is released, `tick` and `mode_1x` are low until a non-reserved code has been held for at least one cycle.
- R2: A code change is a select value at a rising edge that differs from the value at the previous edge.
  - The cycle after such an edge carries no tick.
  - For an internal rate with divisor D, the first tick is high in the cycle that follows the (D+1)-th rising edge, counting the edge that first samples the new code as the first.
- R3: Codes 0 to 21 give one-cycle ticks spaced exactly D reference cycles apart.
  - With the scaling parameter at 1, D for codes 0 upward is 4608, 3072, 1536, 1152, 768, 512, 384, 256, 192, 128, 96, 64, 48, 32, 24, 16, 12, 8, 6, 4, 2 and 1.
  - These are the 16x ticks for 50, 75, 150, 200, 300, 450, 600, 900, 1200, 1800, 2400, 3600, 4800, 7200, 9600, 14.4k, 19.2k, 28.8k, 38.4k, 57.6k, 115.2k and 230.4k baud from a 3.6864 MHz reference.
- R4: Every internal divisor is multiplied by the parameter PRESCALE. Doubling the reference frequency with PRESCALE=2 therefore keeps every baud rate the same.
- R5: Codes 22 and 23 follow `gp_clk[0]` and `gp_clk[1]`. Each rising edge of the selected input gives exactly one tick. The tick is high in the cycle after the second rising clock edge following the first edge that samples the input high.
- R6: Codes 24 and 25 follow `tmr_clk[0]` and `tmr_clk[1]`, with the same edge-to-tick behaviour as R5.
- R7: Code 27 follows `pin_clk` as a 16x clock: one tick per rising edge, as in R5, with `mode_1x` low.
- R8: Code 28 follows `pin_clk` as a 1x clock: one tick per rising edge, with `mode_1x` high from the cycle after the second consecutive edge that samples code 28.
- R9: Reserved codes 26, 29, 30 and 31 produce no ticks and keep `mode_1x` low, whatever the external inputs do.
- R10: Inputs that the current code does not select have no effect on `tick`, and an input held high produces only the single tick of its rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_code | input | 5 | Source select code |
| gp_clk | input | 2 | General-purpose clock inputs, asynchronous |
| tmr_clk | input | 2 | Counter/timer outputs, asynchronous |
| pin_clk | input | 1 | External pin clock, asynchronous |
| tick | output | 1 | One-cycle baud tick enable |
| mode_1x | output | 1 | High when the pin clock is used as a 1x clock |

## Verification
The hardest condition to reach from the ports is a code change that lands while the divider is part-way through a long count, or several changes on consecutive cycles. Either must restart the divider cleanly and not leak a stale tick. The stimulus reaches this in two ways:

- It switches codes at arbitrary points in the rate sweep and in a burst phase that changes the code on every cycle.
- A behavioural model tracks the settle gap and the restart on every clock.

For the external sources, the bench toggles the unselected inputs faster than the selected one. A tick count that matches only the selected input's edges therefore shows that the other inputs were ignored.

// File: rtl/baud_pkg.sv
package baud_pkg;

    typedef enum logic [2:0] {
        ST_HALT,
        ST_SETTLE,
        ST_DIVIDE,
        ST_FOLLOW,
        ST_FOLLOW_1X
    } src_state_e;

    localparam int unsigned CODE_W    = 5;
    localparam int unsigned EXT_N     = 5;
    localparam int unsigned MAX_BASE  = 4608;
    localparam logic [CODE_W-1:0] CODE_RESET = 5'd31;

    // Divisor of the reference for each internal rate, at unit scaling.
    function automatic int unsigned base_div(input logic [CODE_W-1:0] c);
        int unsigned d;
        unique case (c)
            5'd0:    d = 4608;
            5'd1:    d = 3072;
            5'd2:    d = 1536;
            5'd3:    d = 1152;
            5'd4:    d = 768;
            5'd5:    d = 512;
            5'd6:    d = 384;
            5'd7:    d = 256;
            5'd8:    d = 192;
            5'd9:    d = 128;
            5'd10:   d = 96;
            5'd11:   d = 64;
            5'd12:   d = 48;
            5'd13:   d = 32;
            5'd14:   d = 24;
            5'd15:   d = 16;
            5'd16:   d = 12;
            5'd17:   d = 8;
            5'd18:   d = 6;
            5'd19:   d = 4;
            5'd20:   d = 2;
            default: d = 1;
        endcase
        return d;
    endfunction

    // Steady state that a stored code settles into.
    function automatic src_state_e code_state(input logic [CODE_W-1:0] c);
        src_state_e s;
        if (c <= 5'd21) begin
            s = ST_DIVIDE;
        end else begin
            unique case (c)
                5'd22, 5'd23, 5'd24, 5'd25, 5'd27: s = ST_FOLLOW;
                5'd28:                             s = ST_FOLLOW_1X;
                default:                           s = ST_HALT;
            endcase
        end
        return s;
    endfunction

    // Index into the synchronized external vector {pin, tmr1, tmr0, gp1, gp0}.
    function automatic logic [2:0] ext_index(input logic [CODE_W-1:0] c);
        logic [2:0] i;
        unique case (c)
            5'd22:   i = 3'd0;
            5'd23:   i = 3'd1;
            5'd24:   i = 3'd2;
            5'd25:   i = 3'd3;
            default: i = 3'd4;
        endcase
        return i;
    endfunction

    function automatic logic is_reserved(input logic [CODE_W-1:0] c);
        return (c == 5'd26) || (c == 5'd29) || (c == 5'd30) || (c == 5'd31);
    endfunction

endpackage

// File: rtl/baud_edge_sync.sv
module baud_edge_sync #(
    parameter int unsigned WIDTH  = 5,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] rise
);

    localparam int unsigned LAST = STAGES;

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [LAST:0] shreg;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                shreg <= '0;
            end else begin
                shreg <= {shreg[LAST-1:0], async_in[g]};
            end
        end

        assign rise[g] = shreg[LAST-1] & ~shreg[LAST];

        // R5
        edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rise[g] |=> !rise[g]);
    end

endmodule

// File: rtl/baud_div_counter.sv
module baud_div_counter #(
    parameter int unsigned DIV_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_val,
    output logic             hit
);

    logic [DIV_W-1:0] cnt;
    logic             at_end;

    assign at_end = (cnt == div_val - DIV_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (at_end) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end

    assign hit = run & at_end;

    // R3
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < div_val));

    // R3
    hit_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && run && (div_val > DIV_W'(1))) |=> !hit);

endmodule

// File: rtl/baud_src_sel.sv
module baud_src_sel #(
    parameter int unsigned PRESCALE    = 1,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [4:0] sel_code,
    input  logic [1:0] gp_clk,
    input  logic [1:0] tmr_clk,
    input  logic       pin_clk,
    output logic       tick,
    output logic       mode_1x
);
    import baud_pkg::*;

    localparam int unsigned MAX_DIV = MAX_BASE * PRESCALE;
    localparam int unsigned DIV_W   = $clog2(MAX_DIV + 1);

    src_state_e          state, state_nx;
    logic [CODE_W-1:0]   code_q;
    logic [DIV_W-1:0]    div_val;
    logic                div_hit;
    logic [EXT_N-1:0]    ext_raw;
    logic [EXT_N-1:0]    ext_rise;
    logic                ext_pick;

    // Next-state decision.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HALT, ST_SETTLE, ST_DIVIDE, ST_FOLLOW, ST_FOLLOW_1X: begin
                if (sel_code != code_q) begin
                    state_nx = ST_SETTLE;
                end else begin
                    state_nx = code_state(code_q);
                end
            end
            default: state_nx = ST_HALT;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_HALT;
            code_q <= CODE_RESET;
        end else begin
            state  <= state_nx;
            code_q <= sel_code;
        end
    end

    always_comb div_val = DIV_W'(base_div(code_q) * PRESCALE);

    baud_div_counter #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state == ST_DIVIDE),
        .div_val (div_val),
        .hit     (div_hit)
    );

    assign ext_raw = {pin_clk, tmr_clk, gp_clk};

    baud_edge_sync #(.WIDTH(EXT_N), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_raw),
        .rise     (ext_rise)
    );

    assign ext_pick = ext_rise[ext_index(code_q)];

    // Output process.
    always_comb begin
        tick    = 1'b0;
        mode_1x = 1'b0;
        unique case (state)
            ST_HALT, ST_SETTLE: ;
            ST_DIVIDE:          tick = div_hit;
            ST_FOLLOW:          tick = ext_pick;
            ST_FOLLOW_1X: begin
                tick    = ext_pick;
                mode_1x = 1'b1;
            end
            default: ;
        endcase
    end

    // R2
    settle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_code != code_q) |=> !tick);

    // R8
    one_x_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_code == 5'd28 && code_q == 5'd28) |=> mode_1x);

    // R9
    reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_reserved(code_q) && state != ST_SETTLE) |-> (!tick && !mode_1x));

    // R7
    one_x_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_code != 5'd28) |=> !mode_1x);

endmodule

// File: tb/baud_src_sel_test.sv
module baud_src_sel_test;

    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] sel_code = 5'd0;
    logic [4:0] ext_in = '0;   // {pin, tmr1, tmr0, gp1, gp0}
    logic       tick, mode_1x, tick_x2, mode_x2;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit model_on = 1'b0;
    string phase_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    baud_src_sel uut (
        .clk(clk), .rst_n(rst_n), .sel_code(sel_code),
        .gp_clk(ext_in[1:0]), .tmr_clk(ext_in[3:2]), .pin_clk(ext_in[4]),
        .tick(tick), .mode_1x(mode_1x)
    );

    baud_src_sel #(.PRESCALE(2)) uut_x2 (
        .clk(clk), .rst_n(rst_n), .sel_code(sel_code),
        .gp_clk(ext_in[1:0]), .tmr_clk(ext_in[3:2]), .pin_clk(ext_in[4]),
        .tick(tick_x2), .mode_1x(mode_x2)
    );

    // Baud rates per code, used to derive divisors independently.
    int rates[22] = '{50, 75, 150, 200, 300, 450, 600, 900, 1200, 1800, 2400,
                      3600, 4800, 7200, 9600, 14400, 19200, 28800, 38400,
                      57600, 115200, 230400};

    function automatic int div_of(int c);
        return 3686400 / (16 * rates[c]);
    endfunction

    // 0 quiet, 1 gap, 2 divided, 3 external, 4 external 1x
    function automatic int mode_of(int c);
        if (c <= 21) return 2;
        if (c == 28) return 4;
        if (c == 22 || c == 23 || c == 24 || c == 25 || c == 27) return 3;
        return 0;
    endfunction

    function automatic int src_of(int c);
        if (c >= 22 && c <= 25) return c - 22;
        return 4;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Behavioural reference model.
    int         m_code, m_mode, m_cnt;
    logic [4:0] h1, h2, h3;

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_code = 31; m_mode = 0; m_cnt = 0;
            h1 = '0; h2 = '0; h3 = '0;
        end else begin
            int nm, nc;
            nm = (int'(sel_code) != m_code) ? 1 : mode_of(m_code);
            if (m_mode == 2) nc = (m_cnt == div_of(m_code) - 1) ? 0 : m_cnt + 1;
            else             nc = 0;
            h3 = h2; h2 = h1; h1 = ext_in;
            m_mode = nm; m_cnt = nc; m_code = int'(sel_code);
        end
    end

    always @(negedge clk) begin
        if (model_on) begin
            bit et;
            logic [4:0] r;
            r  = h2 & ~h3;
            et = (m_mode == 2 && m_cnt == div_of(m_code) - 1) ||
                 ((m_mode == 3 || m_mode == 4) && r[src_of(m_code)]);
            chk(tick == et, {phase_tag, " tick"}, int'(tick), int'(et));
            chk(mode_1x == (m_mode == 4), {phase_tag, " mode_1x"}, int'(mode_1x), int'(m_mode == 4));
        end
    end

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic count_until_tick(output int k);
        k = 0;
        do begin @(negedge clk); k++; end while (!tick && k < 10000);
    endtask

    initial begin
        int k;
        // R1: reset state
        ext_in = 5'b11111;
        repeat (3) begin
            @(negedge clk);
            chk(tick == 0 && mode_1x == 0, "R1 during reset", int'(tick), 0);
        end
        ext_in = '0;
        sel_code = 5'd31;
        @(negedge clk);
        rst_n = 1'b1;
        model_on = 1'b1;
        cyc(4);
        chk(tick == 0 && mode_1x == 0, "R1 after release", int'(tick), 0);

        // R2 / R3 / R4: every internal rate
        for (int c = 0; c <= 21; c++) begin
            int d;
            d = div_of(c);
            phase_tag = "R3";
            sel_code = 5'(c);
            count_until_tick(k);
            chk(k == d + 1, "R2 first tick latency", k, d + 1);
            count_until_tick(k);
            chk(k == d, "R3 tick spacing", k, d);
            if (c >= 6) begin
                // R4: doubled scaling doubles every divisor
                do @(negedge clk); while (!tick_x2);
                k = 0;
                do begin @(negedge clk); k++; end while (!tick_x2 && k < 10000);
                chk(k == 2 * d, "R4 scaled spacing", k, 2 * d);
            end
        end

        // R2: code changes mid count and every cycle
        phase_tag = "R2";
        sel_code = 5'd12; cyc(20);
        sel_code = 5'd19; cyc(2);
        sel_code = 5'd21; cyc(1);
        for (int i = 0; i < 12; i++) begin
            sel_code = (i % 2 == 0) ? 5'd20 : 5'd21;
            @(negedge clk);
            if (i > 0) chk(tick == 0, "R2 no tick while code keeps changing", int'(tick), 0);
        end
        cyc(10);

        // R5..R8, R10: external sources
        for (int j = 0; j < 6; j++) begin
            int c, s, n;
            c = (j < 4) ? 22 + j : (j == 4 ? 27 : 28);
            s = src_of(c);
            phase_tag = (j < 2) ? "R5" : (j < 4) ? "R6" : (j == 4) ? "R7" : "R8";
            ext_in = '0; cyc(6);
            sel_code = 5'(c); cyc(3);
            chk(mode_1x == (c == 28), {phase_tag, " mode flag"}, int'(mode_1x), int'(c == 28));
            n = 0;
            for (int p = 0; p < 5; p++) begin
                for (int q = 0; q < 6; q++) begin
                    logic [4:0] v;
                    v = (q % 2 == 0) ? 5'b11111 : 5'b00000;
                    v[s] = (q < 3);
                    ext_in = v;
                    @(negedge clk);
                    n += int'(tick);
                end
            end
            // R10: selected input held high adds no further ticks
            ext_in = '0; ext_in[s] = 1'b1;
            for (int q = 0; q < 12; q++) begin @(negedge clk); n += int'(tick); end
            chk(n == 6, {phase_tag, " R10 ticks per selected rising edge"}, n, 6);
        end

        // R9: reserved codes
        phase_tag = "R9";
        for (int j = 0; j < 4; j++) begin
            int c, n;
            c = (j == 0) ? 26 : 28 + j;
            ext_in = '0;
            sel_code = 5'(c); cyc(2);
            n = 0;
            for (int q = 0; q < 40; q++) begin
                ext_in = ~ext_in;
                @(negedge clk);
                n += int'(tick) + int'(mode_1x);
            end
            chk(n == 0, "R9 reserved code silent", n, 0);
        end

        model_on = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait (cycles >= WATCHDOG);
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule